// File: doc/BRIEF.md
# Input Change Interrupt Controller

This block watches a 40-pin general-purpose port, organised as five banks of eight pins, and drives one active-low interrupt level. Each bank holds a reference register, which is the last value captured for that bank. A pin counts as changed when it is configured as an input, its mask bit is clear, and its present level differs from the reference bit. The interrupt goes low one clock after any bank has a changed pin. It goes high again once no bank has a changed pin.

A bank stops counting as changed in two ways. Either its changed pins return to their reference levels, or the bank is read. A read strobe for a bank copies that bank's present pin levels into its reference register. That same clock edge also removes the bank's contribution from the interrupt. The captured values appear on a 40-bit read-data output. When changes are spread over several banks, the interrupt stays low until every one of those banks has been read.

Pin synchronisation, the register-access protocol and the open-drain output stage are handled outside this block.

Top module: `pinchg_irq`

## Requirements
- R1: During a synchronous reset (rst_n low at a clock edge), every reference register loads the present pin levels and irq_n is driven to 1. After reset, irq_n stays 1 and rd_data_o equals the pins that were present at reset.
- R2: irq_n goes to 0 one clock edge after a pin that is an input (dir_in bit = 1) and unmasked (mask bit = 0) differs from its reference bit.
- R3: If no read happens and every changed pin returns to its reference level, irq_n returns to 1 one clock edge later.
- R4: rd_stb_i[b] = 1 at a clock edge loads pin bits [8b+7:8b] into bank b's reference register. rd_data_o bits [8b+7:8b] show that reference after the edge. A bank without a strobe keeps its reference.
- R5: A read of bank b removes bank b's contribution at the same edge. With changes in several banks, irq_n stays 0 until every changed bank has been read.
- R6: A pin whose mask bit is 1 never drives irq_n low, whatever its level.
- R7: A pin whose dir_in bit is 0 (output) never drives irq_n low. If that pin is switched to input while it differs from its reference bit, irq_n goes to 0 one edge later.
- R8: If a pin changes in the same cycle that its bank is read, the new level is what gets captured, and it raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 40 | Synchronised pin levels; bank b occupies bits [8b+7:8b] |
| dir_in_i | input | 40 | 1 = pin configured as input |
| mask_i | input | 40 | 1 = pin masked from the interrupt |
| rd_stb_i | input | 5 | One strobe per bank; 1 = bank read this cycle |
| rd_data_o | output | 40 | Reference (captured) value of every bank |
| irq_n_o | output | 1 | Interrupt level, active low |

## Verification
The bench raises changes in banks 0, 2 and 3 at once and then reads them one at a time. A design that cleared globally on the first read would release the interrupt early. A design that tested the old reference at the reading edge would release it one cycle late. Masked pins and output pins are toggled while they differ from their references, which catches a design that ignores either qualifier. Switching an output back to input then has to produce the spurious interrupt. A reset with non-zero pins, and a pin that changes in the same cycle its bank is read, catch references that reset to zero or capture a stale level.

// File: rtl/pinchg_pkg.sv
// Package: shared geometry of the pin-change interrupt controller.
// Assumes banks are equal width and laid out contiguously, bank 0 at the LSBs.
package pinchg_pkg;
    localparam int unsigned PC_NUM_BANKS = 5;
    localparam int unsigned PC_BANK_W    = 8;
    localparam int unsigned PC_PORT_W    = PC_NUM_BANKS * PC_BANK_W;
endpackage

// File: rtl/pinchg_bank.sv
// Module: one bank of the pin-change detector.
// Holds the bank's reference register, compares live pins against it and
// reports a pending flag. A read strobe captures the pins and drops the flag
// in the same cycle. Assumes pins are already synchronised to clk.
module pinchg_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] dir_in_i,
    input  logic [W-1:0] mask_i,
    input  logic         rd_i,
    output logic [W-1:0] ref_o,
    output logic         pend_o
);
    logic [W-1:0] ref_q;
    logic [W-1:0] live_diff;

    // Reference register: seeded at reset, recaptured on a bank read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= pin_i;
        end else if (rd_i) begin
            ref_q <= pin_i;
        end
    end

    // Qualified difference: inputs only, masked bits removed; read hides the bank.
    always_comb begin
        live_diff = (pin_i ^ ref_q) & dir_in_i & ~mask_i;
        pend_o    = !rd_i && (|live_diff);
    end

    assign ref_o = ref_q;

    // R4: a read loads the pins seen at that edge.
    assert_read_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> (ref_q == $past(pin_i)));

    // R4: without a read the reference holds.
    assert_ref_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(ref_q));

    // R6 / R7: a bank fully masked or fully output never flags.
    assert_no_pend_when_disqualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&(mask_i | ~dir_in_i)) |-> !pend_o);

    // R5: after a read the bank is quiet unless its pins moved.
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((pin_i != $past(pin_i)) || !pend_o || $past(rd_i) == 1'b0 && 1'b0 || !pend_o));
endmodule

// File: rtl/pinchg_merge.sv
// Module: combines per-bank pending flags into one registered active-low level.
// Assumes every flag is already qualified by mask, direction and read.
module pinchg_merge #(
    parameter int unsigned NB = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] pend_i,
    output logic          irq_n_o
);
    logic irq_n_q;

    // Interrupt register: low while any bank is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n_q <= 1'b1;
        end else begin
            irq_n_q <= ~(|pend_i);
        end
    end

    assign irq_n_o = irq_n_q;
endmodule

// File: rtl/pinchg_irq.sv
// Module: top of the pin-change interrupt controller.
// Instantiates one comparator bank per port bank and a merge stage.
// Assumes pins are synchronised and that read strobes come from the register
// access logic, one bit per bank, in bank order.
module pinchg_irq
    import pinchg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = PC_NUM_BANKS,
    parameter int unsigned BANK_W    = PC_BANK_W,
    localparam int unsigned PORT_W   = NUM_BANKS * BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORT_W-1:0]    pin_i,
    input  logic [PORT_W-1:0]    dir_in_i,
    input  logic [PORT_W-1:0]    mask_i,
    input  logic [NUM_BANKS-1:0] rd_stb_i,
    output logic [PORT_W-1:0]    rd_data_o,
    output logic                 irq_n_o
);
    logic [NUM_BANKS-1:0] bank_pend;

    // One detector per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pinchg_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pin_i[b*BANK_W +: BANK_W]),
            .dir_in_i (dir_in_i[b*BANK_W +: BANK_W]),
            .mask_i   (mask_i[b*BANK_W +: BANK_W]),
            .rd_i     (rd_stb_i[b]),
            .ref_o    (rd_data_o[b*BANK_W +: BANK_W]),
            .pend_o   (bank_pend[b])
        );
    end

    pinchg_merge #(.NB(NUM_BANKS)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (bank_pend),
        .irq_n_o (irq_n_o)
    );

    // R2: a low interrupt is always backed by a pending bank one cycle earlier.
    assert_irq_backed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> $past(|bank_pend));

    // R1: the interrupt is released when leaving reset.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_n_o);
endmodule

// File: tb/pinchg_irq_tb.sv
module pinchg_irq_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 13;
    // {pin, dir_in, mask, rd_stb, exp_irq_n, exp_rd_data}
    localparam logic [165:0] VEC [NV] = '{
        {40'h00_0000_0000, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 5'b00000, 1'b1, 40'h00_0000_0000}, // R1 idle
        {40'h00_0000_0020, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 5'b00000, 1'b0, 40'h00_0000_0000}, // R2
        {40'h00_0000_0000, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 5'b00000, 1'b1, 40'h00_0000_0000}, // R3
        {40'h00_8008_0020, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 5'b00000, 1'b0, 40'h00_0000_0000}, // R2 three banks
        {40'h00_8008_0020, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 5'b00001, 1'b0, 40'h00_0000_0020}, // R5 bank0 read
        {40'h00_8008_0020, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 5'b00100, 1'b0, 40'h00_0008_0020}, // R5 bank2 read
        {40'h00_8008_0020, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 5'b01000, 1'b1, 40'h00_8008_0020}, // R5 bank3 read
        {40'hFF_8008_0020, 40'hFF_FFFF_FFFF, 40'hFF_0000_0000, 5'b00000, 1'b1, 40'h00_8008_0020}, // R6 masked
        {40'hFF_8008_FF20, 40'hFF_FFFF_00FF, 40'hFF_0000_0000, 5'b00000, 1'b1, 40'h00_8008_0020}, // R7 outputs
        {40'hFF_8008_FF20, 40'hFF_FFFF_FFFF, 40'hFF_0000_0000, 5'b00000, 1'b0, 40'h00_8008_0020}, // R7 spurious
        {40'hFF_8008_FF20, 40'hFF_FFFF_FFFF, 40'hFF_0000_0000, 5'b00010, 1'b1, 40'h00_8008_FF20}, // R4 bank1 read
        {40'hFF_8008_FF20, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 5'b00000, 1'b0, 40'h00_8008_FF20}, // R6 unmask
        {40'hFF_8008_FF20, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 5'b10000, 1'b1, 40'hFF_8008_FF20}  // R4 bank4 read
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] pin_i = '0;
    logic [39:0] dir_in_i = '1;
    logic [39:0] mask_i = '0;
    logic [4:0]  rd_stb_i = '0;
    logic [39:0] rd_data_o;
    logic        irq_n_o;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinchg_irq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .dir_in_i  (dir_in_i),
        .mask_i    (mask_i),
        .rd_stb_i  (rd_stb_i),
        .rd_data_o (rd_data_o),
        .irq_n_o   (irq_n_o)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, let a posedge pass, sample at next negedge.
    task automatic step(input logic [39:0] p, input logic [39:0] d,
                        input logic [39:0] m, input logic [4:0] r);
        pin_i = p; dir_in_i = d; mask_i = m; rd_stb_i = r;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", {39'b0, irq_n_o}, 40'h1);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][165:126], VEC[i][125:86], VEC[i][85:46], VEC[i][45:41]);
            chk($sformatf("vec%0d irq R2/R3/R5/R6/R7", i), {39'b0, irq_n_o}, {39'b0, VEC[i][40]});
            chk($sformatf("vec%0d data R4/R5", i), rd_data_o, VEC[i][39:0]);
        end
        // R1: reset with non-zero pins seeds references with them.
        rst_n = 1'b0;
        step(40'hA5_3C_96_0F_71, '1, '0, '0);
        step(40'hA5_3C_96_0F_71, '1, '0, '0);
        rst_n = 1'b1;
        step(40'hA5_3C_96_0F_71, '1, '0, '0);
        chk("R1 irq idle with nonzero pins", {39'b0, irq_n_o}, 40'h1);
        chk("R1 refs seeded from pins", rd_data_o, 40'hA5_3C_96_0F_71);
        // R8: pin moves in the very cycle bank 0 is read.
        step(40'hA5_3C_96_0F_8E, '1, '0, 5'b00001);
        chk("R8 irq stays high", {39'b0, irq_n_o}, 40'h1);
        chk("R8 new level captured", rd_data_o, 40'hA5_3C_96_0F_8E);
        step(40'hA5_3C_96_0F_8E, '1, '0, '0);
        chk("R8 no later interrupt", {39'b0, irq_n_o}, 40'h1);
        // R3: change in bank 2, then return before any read.
        step(40'hA5_3C_97_0F_8E, '1, '0, '0);
        chk("R2 bank2 change", {39'b0, irq_n_o}, 40'h0);
        step(40'hA5_3C_96_0F_8E, '1, '0, '0);
        chk("R3 return releases", {39'b0, irq_n_o}, 40'h1);
        chk("R4 no read keeps refs", rd_data_o, 40'hA5_3C_96_0F_8E);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule